// File: doc/BRIEF.md
# Burst Address Counter With Readback

This block is the address front end of one memory port. Each clock it decodes three active-low controls: clear, load strobe and advance. From them it updates a counter register, and that register drives the word address and the lane enables of the memory behind it. The counter can be cleared to zero, loaded from an external address, stepped by one, or held. A load strobe given without advance, during a selected read, holds the counter. In that case the port's read data carries the counter value in place of memory data, so software or a bus master can see where a burst has reached.

The port can run at full word width (four lanes), half width (two lanes) or quarter width (one lane). In the narrow modes the counter steps in beats rather than words: its lowest one or two bits pick the lane, and the rest form the word address. A most-significant-first flag reverses the lane order within a word. The memory array sits outside the block. It returns a full word for the current word address on `mem_rdata`, and the block registers the selected lane, or the readback value, onto `rd_data`. In quarter-width mode the counter does not fit one lane, so readback takes two output beats.

Top module: `burst_addr_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, the counter becomes zero whatever `ld_n`, `adv_n` and `ext_addr` are.
- R2: A selected read issued in the same cycle as a clear accesses location 0, and its data appears on `rd_data` with no dead cycle.
- R3: With `clr_n` high and both `ld_n` and `adv_n` low, the counter loads `ext_addr`, and that cycle's access uses the loaded address.
- R4: With `clr_n` high, `ld_n` high and `adv_n` low, the counter increases by one per edge and `ext_addr` is ignored.
- R5: With `clr_n` high and `adv_n` high, the counter keeps its value whether `ld_n` is high or low, and `ext_addr` is ignored.
- R6: With `clr_n` high, `ld_n` low, `adv_n` high, `sel_n` low and `rd_wr_n` high, the counter holds, and the next `rd_data` is the counter value in its low bits with zeros above, with `rd_valid` high.
- R7: The counter range depends on the mode: 2^ADDR_W beats at full width (`width_sel`=00), 2^(ADDR_W+1) at half width (01) and 2^(ADDR_W+2) at quarter width (10 or 11). A load drops `ext_addr` bits above the range, and an increment from the last value wraps to 0.
- R8: Counter operations act in the same way while `sel_n` is high. A deselected cycle or a write cycle (`rd_wr_n` low) gives `rd_valid` low on the next edge.
- R9: After `rst`, the counter is 0, `rd_valid` is 0 and `rd_data` is 0. An operation sampled at edge k shows on `mem_addr` and `mem_lane` after edge k, and its read data shows on `rd_data` and `rd_valid` after edge k+1.
- R10: At half width, `mem_addr` is counter bits [ADDR_W:1] and counter bit 0 is the beat. With `msb_first` low, beat 0 selects `mem_rdata[2*LANE_W-1:0]` (`mem_lane`=0011) and beat 1 the upper half (1100). The half appears in the low bits of `rd_data` with zeros above.
- R11: With `msb_first` high, the lane order inside a word is reversed: at half width beat 0 selects the upper half, and at quarter width beat b selects lane 3-b.
- R12: At quarter width, `mem_addr` is counter bits [ADDR_W+1:2] and counter bits [1:0] are the beat. Lane k is `mem_rdata[LANE_W*k+LANE_W-1:LANE_W*k]`, `mem_lane` is one-hot on the selected lane, and the lane appears in the low LANE_W bits of `rd_data` with zeros above.
- R13: A quarter-width readback gives two valid output beats on consecutive edges: first counter bits [LANE_W-1:0], then the counter bits above LANE_W shifted down. Each beat is zero-filled above LANE_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 2 | Port width: 00 full, 01 half, 10/11 quarter; held static |
| msb_first | input | 1 | 1 reverses lane order inside a word |
| sel_n | input | 1 | Active-low port select for read output |
| rd_wr_n | input | 1 | 1 read, 0 write |
| clr_n | input | 1 | Active-low counter clear, highest priority |
| ld_n | input | 1 | Active-low load strobe |
| adv_n | input | 1 | Active-low advance (count enable) |
| ext_addr | input | ADDR_W+2 | External beat address |
| mem_rdata | input | 4*LANE_W | Word read from memory at `mem_addr` |
| mem_addr | output | ADDR_W | Word address to the memory |
| mem_lane | output | 4 | Lanes addressed by the current beat |
| rd_data | output | 4*LANE_W | Registered read data or counter readback |
| rd_valid | output | 1 | `rd_data` carries a new beat |

## Verification
The properties take the width mode to be static across any readback: a mode switch between the two quarter-width beats, or on the cycle just before a full-width readback, is outside what they claim. The width and order inputs are also taken as stable in the cycles around each access. The stimulus changes `width_sel` and `msb_first` only on the step where a fresh load is issued. After a quarter-width readback it issues a plain hold with no read, so the second beat never competes with new read data.

// File: rtl/bac_pkg.sv
package bac_pkg;

  // number of lanes in one memory word (full width = all lanes)
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    W_FULL = 2'b00,
    W_HALF = 2'b01,
    W_QUAD = 2'b10,
    W_QALT = 2'b11
  } bac_width_e;

  typedef enum logic [2:0] {
    OP_CLR,
    OP_LOAD,
    OP_INC,
    OP_HOLD,
    OP_PEEK
  } bac_op_e;

endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    adv_n,
  output bac_op_e op
);

  // clear dominates; advance only matters with clear released
  always_comb begin
    if (!clr_n)      op = OP_CLR;
    else if (!adv_n) op = ld_n ? OP_INC : OP_LOAD;
    else             op = ld_n ? OP_HOLD : OP_PEEK;
  end

endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  bac_op_e          op,
  input  bac_width_e       width,
  input  logic [CNT_W-1:0] ext_addr,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] range_mask;
  logic [CNT_W-1:0] cnt_d;

  assign ones = '1;

  // range shrinks by one beat bit per step toward full width
  always_comb begin
    case (width)
      W_FULL:  range_mask = ones >> 2;
      W_HALF:  range_mask = ones >> 1;
      default: range_mask = ones;
    endcase
  end

  always_comb begin
    case (op)
      OP_CLR:  cnt_d = '0;
      OP_LOAD: cnt_d = ext_addr & range_mask;
      OP_INC:  cnt_d = (cnt_q + CNT_W'(1)) & range_mask;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bac_addr_map.sv
module bac_addr_map
  import bac_pkg::*;
#(
  parameter int ADDR_W = 15,
  localparam int CNT_W = ADDR_W + 2
) (
  input  logic [CNT_W-1:0] cnt,
  input  bac_width_e       width,
  input  logic             msb_first,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  lane_oh,
  output logic [1:0]        beat
);

  always_comb begin
    case (width)
      W_FULL: begin
        mem_addr = cnt[ADDR_W-1:0];
        beat     = 2'b00;
        lane_oh  = 4'b1111;
      end
      W_HALF: begin
        mem_addr = cnt[ADDR_W:1];
        beat     = {1'b0, cnt[0] ^ msb_first};
        lane_oh  = beat[0] ? 4'b1100 : 4'b0011;
      end
      default: begin
        mem_addr = cnt[ADDR_W+1:2];
        beat     = cnt[1:0] ^ {2{msb_first}};
        lane_oh  = 4'b0001 << beat;
      end
    endcase
  end

endmodule

// File: rtl/bac_out_sel.sv
module bac_out_sel
  import bac_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int CNT_W  = 17,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  bac_width_e        width,
  input  logic [1:0]        beat,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rd_q,
  input  logic              rb_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam logic [DATA_W-1:0] LANE_MASK = DATA_W'({LANE_W{1'b1}});
  localparam logic [DATA_W-1:0] HALF_MASK = DATA_W'({(2*LANE_W){1'b1}});

  logic [LANE_W-1:0] lane [LANES];
  logic [DATA_W-1:0] mem_part;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] rb_val;
  logic [DATA_W-1:0] hi_ext;
  logic [DATA_W-1:0] snap_q;
  logic              hi_pend_q;
  logic              is_quad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = mem_rdata[g*LANE_W +: LANE_W];
  end

  assign is_quad = (width != W_FULL) && (width != W_HALF);
  assign cnt_ext = DATA_W'(cnt);
  assign hi_ext  = (cnt_ext >> LANE_W) & LANE_MASK;

  always_comb begin
    case (width)
      W_FULL: begin
        mem_part = mem_rdata;
        rb_val   = cnt_ext;
      end
      W_HALF: begin
        mem_part = DATA_W'({lane[{beat[0], 1'b1}], lane[{beat[0], 1'b0}]});
        rb_val   = cnt_ext & HALF_MASK;
      end
      default: begin
        mem_part = DATA_W'(lane[beat]);
        rb_val   = cnt_ext & LANE_MASK;
      end
    endcase
  end

  // second quarter-width readback beat takes precedence over new data
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      hi_pend_q <= 1'b0;
      snap_q    <= '0;
    end else if (hi_pend_q) begin
      rd_data   <= snap_q;
      rd_valid  <= 1'b1;
      hi_pend_q <= 1'b0;
    end else if (rb_q) begin
      rd_data   <= rb_val;
      rd_valid  <= 1'b1;
      hi_pend_q <= is_quad;
      snap_q    <= hi_ext;
    end else if (rd_q) begin
      rd_data   <= mem_part;
      rd_valid  <= 1'b1;
    end else begin
      rd_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int  ADDR_W = 15,
  parameter int  LANE_W = 9,
  localparam int CNT_W  = ADDR_W + 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        width_sel,
  input  logic              msb_first,
  input  logic              sel_n,
  input  logic              rd_wr_n,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              adv_n,
  input  logic [CNT_W-1:0]  ext_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_lane,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  bac_width_e       width;
  bac_op_e          op;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       beat;
  logic             rd_q;
  logic             rb_q;

  assign width = bac_width_e'(width_sel);

  bac_decode u_dec (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .adv_n (adv_n),
    .op    (op)
  );

  bac_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .width    (width),
    .ext_addr (ext_addr),
    .cnt_q    (cnt_q)
  );

  bac_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .cnt       (cnt_q),
    .width     (width),
    .msb_first (msb_first),
    .mem_addr  (mem_addr),
    .lane_oh   (mem_lane),
    .beat      (beat)
  );

  // access qualifiers travel with the counter register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      rb_q <= 1'b0;
    end else begin
      rd_q <= !sel_n && rd_wr_n;
      rb_q <= !sel_n && rd_wr_n && (op == OP_PEEK);
    end
  end

  bac_out_sel #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .width     (width),
    .beat      (beat),
    .mem_rdata (mem_rdata),
    .cnt       (cnt_q),
    .rd_q      (rd_q),
    .rb_q      (rb_q),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int  ADDR_W = 15,
  parameter int  LANE_W = 9,
  localparam int CNT_W  = ADDR_W + 2,
  localparam int DATA_W = LANE_W * 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_n,
  input logic              ld_n,
  input logic              adv_n,
  input logic [1:0]        width_sel,
  input logic [CNT_W-1:0]  ext_addr,
  input logic [CNT_W-1:0]  cnt,
  input logic              rb_q,
  input logic [3:0]        mem_lane,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);

  function automatic logic [CNT_W-1:0] span(input logic [1:0] w);
    logic [CNT_W-1:0] o;
    o = '1;
    case (w)
      2'b00:   return o >> 2;
      2'b01:   return o >> 1;
      default: return o;
    endcase
  endfunction

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (cnt == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n && !adv_n) |=> (cnt == ($past(ext_addr) & span($past(width_sel)))));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !adv_n) |=> (cnt == (($past(cnt) + CNT_W'(1)) & span($past(width_sel)))));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && adv_n) |=> $stable(cnt));

  p_peek_r6: assert property (@(posedge clk) disable iff (rst)
    (rb_q && width_sel == 2'b00 && $past(width_sel) == 2'b00)
      |=> (rd_valid && rd_data == DATA_W'($past(cnt))));

  p_half_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(width_sel) == 2'b01) |-> (rd_data[DATA_W-1:2*LANE_W] == '0));

  p_half_lanes_r10: assert property (@(posedge clk) disable iff (rst)
    (width_sel == 2'b01) |-> ($countones(mem_lane) == 2));

  p_quad_lane_r12: assert property (@(posedge clk) disable iff (rst)
    (width_sel[1]) |-> ($onehot0(mem_lane) && mem_lane != 4'b0000));

  p_quad_fill_r13: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(width_sel[1])) |-> (rd_data[DATA_W-1:LANE_W] == '0));

endmodule

bind burst_addr_counter bac_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .adv_n     (adv_n),
  .width_sel (width_sel),
  .ext_addr  (ext_addr),
  .cnt       (cnt_q),
  .rb_q      (rb_q),
  .mem_lane  (mem_lane),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid)
);

// File: tb/burst_addr_counter_test.sv
module burst_addr_counter_test;

  localparam int AW = 15;
  localparam int LW = 9;
  localparam int CW = AW + 2;
  localparam int DW = LW * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    width_sel = 2'b00;
  logic          msb_first = 1'b0;
  logic          sel_n = 1'b1;
  logic          rd_wr_n = 1'b1;
  logic          clr_n = 1'b1;
  logic          ld_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [CW-1:0] ext_addr = '0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_lane;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    for (int k = 0; k < 4; k++) w[k*LW +: LW] = LW'(int'(a) * 3 + k * 101);
    return w;
  endfunction

  assign mem_rdata = word_of(mem_addr);

  burst_addr_counter #(.ADDR_W(AW), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .width_sel(width_sel), .msb_first(msb_first),
    .sel_n(sel_n), .rd_wr_n(rd_wr_n), .clr_n(clr_n), .ld_n(ld_n), .adv_n(adv_n),
    .ext_addr(ext_addr), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_lane(mem_lane), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one operation, return after the following falling edge
  task automatic step(input logic c, input logic l, input logic a,
                      input logic s, input logic r, input logic [CW-1:0] x);
    clr_n = c; ld_n = l; adv_n = a; sel_n = s; rd_wr_n = r; ext_addr = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();               step(1, 1, 1, 1, 1, '0); endtask
  task automatic load_rd(input logic [CW-1:0] x); step(1, 0, 0, 0, 1, x); endtask
  task automatic load_q(input logic [CW-1:0] x);  step(1, 0, 0, 1, 1, x); endtask
  task automatic inc_rd(input logic [CW-1:0] x);  step(1, 1, 0, 0, 1, x); endtask
  task automatic peek();              step(1, 0, 1, 0, 1, 17'h00001); endtask

  task automatic t_reset();
    chk("R9 reset mem_addr", mem_addr, 0);
    chk("R9 reset rd_valid", rd_valid, 0);
    chk("R9 reset rd_data", rd_data, 0);
    chk("R9 reset mem_lane", mem_lane, 4'b1111);
  endtask

  task automatic t_load();
    load_rd(17'h01234);
    chk("R3 load addr", mem_addr, 15'h1234);
    chk("R9 full lanes", mem_lane, 4'b1111);
    nop();
    chk("R9 read data", rd_data, word_of(15'h1234));
    chk("R9 read valid", rd_valid, 1);
  endtask

  task automatic t_inc();
    inc_rd(17'h07777);
    chk("R4 inc 1", mem_addr, 15'h1235);
    inc_rd(17'h00000);
    chk("R4 inc 2", mem_addr, 15'h1236);
    chk("R4 data 1", rd_data, word_of(15'h1235));
    inc_rd(17'h1FFFF);
    chk("R4 inc 3", mem_addr, 15'h1237);
    nop();
    chk("R4 data 3", rd_data, word_of(15'h1237));
  endtask

  task automatic t_hold();
    step(1, 1, 1, 0, 1, 17'h00F0F);
    chk("R5 hold addr", mem_addr, 15'h1237);
    nop();
    chk("R5 hold data", rd_data, word_of(15'h1237));
    nop();
    chk("R9 idle valid", rd_valid, 0);
  endtask

  task automatic t_peek();
    peek();
    chk("R5 peek holds", mem_addr, 15'h1237);
    nop();
    chk("R6 readback value", rd_data, 36'h000001237);
    chk("R6 readback valid", rd_valid, 1);
  endtask

  task automatic t_clear();
    step(0, 0, 0, 0, 1, 17'h00055);
    chk("R1 clear addr", mem_addr, 0);
    nop();
    chk("R2 clear read", rd_data, word_of(15'h0000));
    chk("R2 clear valid", rd_valid, 1);
  endtask

  task automatic t_wrap();
    load_q(17'h07FFF);
    inc_rd(17'h00000);
    chk("R7 full wrap", mem_addr, 0);
    load_q(17'h1ABCD);
    chk("R7 full mask", mem_addr, 15'h2BCD);
  endtask

  task automatic t_desel();
    step(1, 0, 0, 1, 1, 17'h00100);
    chk("R8 desel load", mem_addr, 15'h0100);
    step(1, 1, 0, 1, 1, 17'h00000);
    chk("R8 desel inc", mem_addr, 15'h0101);
    chk("R8 desel valid", rd_valid, 0);
    step(1, 1, 0, 0, 0, 17'h00000);
    chk("R8 write inc", mem_addr, 15'h0102);
    nop();
    chk("R8 write valid", rd_valid, 0);
  endtask

  task automatic t_half();
    logic [DW-1:0] w;
    width_sel = 2'b01; msb_first = 1'b0;
    load_rd(17'h00005);
    chk("R10 half addr", mem_addr, 15'h0002);
    chk("R10 half lane b1", mem_lane, 4'b1100);
    nop();
    w = word_of(15'h0002);
    chk("R10 half upper", rd_data, {18'h0, w[35:18]});
    inc_rd(17'h00000);
    chk("R10 half inc addr", mem_addr, 15'h0003);
    chk("R10 half lane b0", mem_lane, 4'b0011);
    nop();
    w = word_of(15'h0003);
    chk("R10 half lower", rd_data, {18'h0, w[17:0]});
    msb_first = 1'b1;
    load_rd(17'h00004);
    chk("R11 half msb lane", mem_lane, 4'b1100);
    nop();
    w = word_of(15'h0002);
    chk("R11 half msb data", rd_data, {18'h0, w[35:18]});
    load_q(17'h0FFFF);
    inc_rd(17'h00000);
    chk("R7 half wrap", mem_addr, 0);
    chk("R11 half wrap lane", mem_lane, 4'b1100);
    load_q(17'h1ABCD);
    chk("R7 half mask", mem_addr, 15'h55E6);
    peek();
    nop();
    chk("R6 half readback", rd_data, 36'h00000ABCD);
  endtask

  task automatic t_quad();
    logic [DW-1:0] w;
    width_sel = 2'b10; msb_first = 1'b0;
    load_rd(17'h12345);
    chk("R12 quad addr", mem_addr, 15'h48D1);
    chk("R12 quad lane", mem_lane, 4'b0010);
    nop();
    w = word_of(15'h48D1);
    chk("R12 quad data", rd_data, {27'h0, w[17:9]});
    msb_first = 1'b1;
    load_rd(17'h12345);
    chk("R11 quad msb lane", mem_lane, 4'b0100);
    nop();
    chk("R11 quad msb data", rd_data, {27'h0, w[26:18]});
    load_q(17'h1FFFF);
    inc_rd(17'h00000);
    chk("R7 quad wrap", mem_addr, 0);
    chk("R11 quad wrap lane", mem_lane, 4'b1000);
    msb_first = 1'b0;
    load_q(17'h12345);
    peek();
    chk("R13 peek holds", mem_addr, 15'h48D1);
    nop();
    chk("R13 beat 1", rd_data, 36'h000000145);
    chk("R13 beat 1 valid", rd_valid, 1);
    nop();
    chk("R13 beat 2", rd_data, 36'h000000091);
    chk("R13 beat 2 valid", rd_valid, 1);
    nop();
    chk("R13 after beats", rd_valid, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_inc();
    t_hold();
    t_peek();
    t_clear();
    t_wrap();
    t_desel();
    t_half();
    t_quad();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule